// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating converter. It runs the analog front end through a repeating conversion made of three phases. First the offsets are nulled (auto-zero). Then the unknown input is integrated for a fixed time. Finally a reference of the opposite polarity is integrated until the comparator reports that the integrator output is back at zero. All phase lengths are measured in counts, and one count is one tick of the oscillator clock divided by `DIV`.

The controller drives three one-hot switch enables and a reference-polarity select. At the end of the signal phase it latches the input polarity from the integrator-sign input. During de-integration it counts ticks until the comparator reports the zero crossing; that count is the reading, proportional to Vin/Vref. If no crossing arrives within the de-integrate limit, the phase ends anyway, the reading is clamped and an overrange flag is set. The full conversion always lasts `CYCLE_COUNTS` ticks, because auto-zero takes up whatever counts de-integration did not use. The reading, the sign and the overrange flag are published together with a one-cycle done strobe.

Top module: `dslope_seq`

## Requirements
- R1: Exactly one of `az_en`, `si_en`, `ri_en` is high at any time. The phases follow the order auto-zero, signal integrate, reference integrate, and then repeat.
- R2: The count tick occurs once every `DIV` clock cycles. Phase changes happen only on a tick, so every phase lasts a whole multiple of `DIV` clocks.
- R3: Signal integrate lasts exactly `SIG_COUNTS` ticks (default 1000).
- R4: On the last tick of signal integrate, `int_neg` (1 = negative input) is latched as the polarity. During reference integrate, `ref_neg` is 1 when the latched polarity is positive and 0 when it is negative; outside reference integrate it is 0.
- R5: `cmp_in` (1 = integrator at zero) passes through a two-flop synchronizer. Reference integrate ends on the first tick at which the synchronized comparator is 1. The reading is the number of ticks of that phase that came before that tick, so it lies between 0 and `DEINT_MAX`-1.
- R6: If the synchronized comparator is still 0 on tick `DEINT_MAX` of reference integrate (default 2000), the phase ends, `overrange` is set and `result` is clamped to `DEINT_MAX`-1. A conversion that ends on a crossing clears `overrange`.
- R7: Auto-zero lasts `CYCLE_COUNTS - SIG_COUNTS - n` ticks, where n is the number of ticks the previous reference-integrate phase used. The first auto-zero after reset lasts `CYCLE_COUNTS - SIG_COUNTS - DEINT_MAX` ticks. Signal integrate therefore starts every `CYCLE_COUNTS * DIV` clocks.
- R8: `done` is high for exactly one clock, in the first cycle of auto-zero. `result`, `result_neg` and `overrange` change only in that cycle and hold their values through the next conversion.
- R9: A synchronous active-high `rst` selects auto-zero with all counters cleared and `result`, `result_neg`, `overrange`, `done` and `ref_neg` all 0.
- R10: The comparator has no effect during auto-zero and signal integrate. A comparator that is already high when reference integrate begins gives a reading of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Zero-crossing comparator, asynchronous |
| int_neg | input | 1 | Integrator sign, 1 = input negative |
| az_en | output | 1 | Auto-zero switches closed |
| si_en | output | 1 | Signal-integrate switches closed |
| ri_en | output | 1 | Reference-integrate switches closed |
| ref_neg | output | 1 | Apply the negative reference |
| result | output | RES_W | Latched reading in counts |
| result_neg | output | 1 | Latched sign of the reading |
| overrange | output | 1 | Latched overrange flag |
| done | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The hardest corners are the edges of the de-integrate window. One is a comparator that is already high when reference integrate starts, which must give a reading of zero and not a reading delayed by the synchronizer. The other is a comparator that never rises and so runs into the clamp. The bench reaches both by placing its comparator edge relative to the observed phase enables: it raises the comparator during signal integrate for one conversion and holds it low for a whole conversion for the other. A comparator pulse that falls entirely within signal integrate confirms that the input is ignored there. The behavioural model follows every case clock by clock.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [1:0] {
        PH_AZ = 2'd0,
        PH_SI = 2'd1,
        PH_RI = 2'd2
    } dsq_phase_e;

    typedef struct packed {
        logic az;
        logic si;
        logic ri;
    } dsq_sw_t;

    function automatic dsq_sw_t dsq_decode(input dsq_phase_e ph);
        dsq_sw_t sw;
        sw.az = (ph == PH_AZ);
        sw.si = (ph == PH_SI);
        sw.ri = (ph == PH_RI);
        return sw;
    endfunction

endpackage

// File: rtl/dsq_tick_div.sv
module dsq_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || div_q == LAST) div_q <= '0;
        else                      div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/dsq_sync2.sv
module dsq_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[0], d_async};
    end

    assign q_sync = stg[1];
endmodule

// File: rtl/dsq_phase_ctl.sv
module dsq_phase_ctl
    import dsq_pkg::*;
#(
    parameter int SIG_COUNTS   = 1000,
    parameter int DEINT_MAX    = 2000,
    parameter int CYCLE_COUNTS = 4000,
    parameter int RES_W        = $clog2(DEINT_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             zero_hit,
    input  logic             int_neg,
    output dsq_phase_e       phase,
    output logic             pol_neg,
    output logic [RES_W-1:0] result,
    output logic             result_neg,
    output logic             overrange,
    output logic             done
);
    localparam int CNT_W = $clog2(CYCLE_COUNTS + 1);
    localparam logic [CNT_W-1:0] SIG_LAST  = CNT_W'(SIG_COUNTS - 1);
    localparam logic [CNT_W-1:0] RI_LAST   = CNT_W'(DEINT_MAX - 1);
    localparam logic [CNT_W-1:0] AZ_BASE   = CNT_W'(CYCLE_COUNTS - SIG_COUNTS - 1);
    localparam logic [CNT_W-1:0] AZ_FIRST  = CNT_W'(CYCLE_COUNTS - SIG_COUNTS - DEINT_MAX);
    localparam logic [RES_W-1:0] RES_CLAMP = RES_W'(DEINT_MAX - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] az_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_AZ;
            cnt        <= '0;
            az_len     <= AZ_FIRST;
            pol_neg    <= 1'b0;
            result     <= '0;
            result_neg <= 1'b0;
            overrange  <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (phase)
                    PH_AZ: begin
                        if (cnt == az_len - 1'b1) begin
                            phase <= PH_SI;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_SI: begin
                        if (cnt == SIG_LAST) begin
                            phase   <= PH_RI;
                            cnt     <= '0;
                            pol_neg <= int_neg;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_RI: begin
                        if (zero_hit || cnt == RI_LAST) begin
                            phase      <= PH_AZ;
                            cnt        <= '0;
                            done       <= 1'b1;
                            result     <= zero_hit ? cnt[RES_W-1:0] : RES_CLAMP;
                            overrange  <= !zero_hit;
                            result_neg <= pol_neg;
                            az_len     <= AZ_BASE - cnt;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        phase <= PH_AZ;
                        cnt   <= '0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dsq_pkg::*;
#(
    parameter int DIV          = 4,
    parameter int SIG_COUNTS   = 1000,
    parameter int DEINT_MAX    = 2000,
    parameter int CYCLE_COUNTS = 4000,
    parameter int RES_W        = $clog2(DEINT_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_in,
    input  logic             int_neg,
    output logic             az_en,
    output logic             si_en,
    output logic             ri_en,
    output logic             ref_neg,
    output logic [RES_W-1:0] result,
    output logic             result_neg,
    output logic             overrange,
    output logic             done
);
    logic       tick;
    logic       cmp_s;
    logic       pol_neg;
    dsq_phase_e phase;
    dsq_sw_t    sw;

    dsq_tick_div #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dsq_sync2 u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (cmp_in),
        .q_sync  (cmp_s)
    );

    dsq_phase_ctl #(
        .SIG_COUNTS   (SIG_COUNTS),
        .DEINT_MAX    (DEINT_MAX),
        .CYCLE_COUNTS (CYCLE_COUNTS),
        .RES_W        (RES_W)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .zero_hit   (cmp_s),
        .int_neg    (int_neg),
        .phase      (phase),
        .pol_neg    (pol_neg),
        .result     (result),
        .result_neg (result_neg),
        .overrange  (overrange),
        .done       (done)
    );

    assign sw      = dsq_decode(phase);
    assign az_en   = sw.az;
    assign si_en   = sw.si;
    assign ri_en   = sw.ri;
    assign ref_neg = sw.ri & ~pol_neg;
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
    parameter int DIV          = 4,
    parameter int SIG_COUNTS   = 1000,
    parameter int DEINT_MAX    = 2000,
    parameter int RES_W        = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             az_en,
    input logic             si_en,
    input logic             ri_en,
    input logic             ref_neg,
    input logic [RES_W-1:0] result,
    input logic             result_neg,
    input logic             overrange,
    input logic             done
);
    int si_clks;

    always_ff @(posedge clk) begin
        if (rst)        si_clks <= 0;
        else if (si_en) si_clks <= si_clks + 1;
        else            si_clks <= 0;
    end

    a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones({az_en, si_en, ri_en}) == 1);

    a_r1_si_after_az: assert property (@(posedge clk) disable iff (rst)
        $rose(si_en) |-> $past(az_en));

    a_r1_ri_after_si: assert property (@(posedge clk) disable iff (rst)
        $rose(ri_en) |-> $past(si_en));

    a_r3_si_length: assert property (@(posedge clk) disable iff (rst)
        $fell(si_en) |-> si_clks == SIG_COUNTS * DIV);

    a_r4_ref_only_in_ri: assert property (@(posedge clk) disable iff (rst)
        !ri_en |-> !ref_neg);

    a_r4_ref_steady: assert property (@(posedge clk) disable iff (rst)
        (ri_en && $past(ri_en)) |-> $stable(ref_neg));

    a_r6_clamp: assert property (@(posedge clk) disable iff (rst)
        overrange |-> result == RES_W'(DEINT_MAX - 1));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_at_az_entry: assert property (@(posedge clk) disable iff (rst)
        done |-> (az_en && $past(ri_en)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(result_neg) && $stable(overrange)));
endmodule

bind dslope_seq dslope_seq_chk #(
    .DIV        (DIV),
    .SIG_COUNTS (SIG_COUNTS),
    .DEINT_MAX  (DEINT_MAX),
    .RES_W      (RES_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .az_en      (az_en),
    .si_en      (si_en),
    .ri_en      (ri_en),
    .ref_neg    (ref_neg),
    .result     (result),
    .result_neg (result_neg),
    .overrange  (overrange),
    .done       (done)
);

// File: tb/dslope_seq_bench.sv
module dslope_seq_bench;
    localparam int DIV   = 4;
    localparam int SIG   = 20;
    localparam int DMAX  = 40;
    localparam int CYC   = 80;
    localparam int RES_W = $clog2(DMAX);
    localparam int NCONV = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp_in = 1'b0;
    logic int_neg = 1'b0;
    logic az_en, si_en, ri_en, ref_neg, result_neg, overrange, done;
    logic [RES_W-1:0] result;

    int total = 0;
    int bad = 0;
    bit model_on = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dslope_seq #(
        .DIV(DIV), .SIG_COUNTS(SIG), .DEINT_MAX(DMAX),
        .CYCLE_COUNTS(CYC), .RES_W(RES_W)
    ) u_dslope_seq (
        .clk(clk), .rst(rst), .cmp_in(cmp_in), .int_neg(int_neg),
        .az_en(az_en), .si_en(si_en), .ri_en(ri_en), .ref_neg(ref_neg),
        .result(result), .result_neg(result_neg), .overrange(overrange),
        .done(done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0=zeroing, 1=signal, 2=reference
    int m_div, m_ph, m_cnt, m_az, m_pol, m_res, m_neg, m_ovr, m_done, m_s1, m_s2;

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_ph = 0; m_cnt = 0; m_az = CYC - SIG - DMAX;
            m_pol = 0; m_res = 0; m_neg = 0; m_ovr = 0; m_done = 0;
            m_s1 = 0; m_s2 = 0;
        end else begin
            m_done = 0;
            if (m_div == DIV - 1) begin
                if (m_ph == 0) begin
                    m_cnt++;
                    if (m_cnt == m_az) begin m_ph = 1; m_cnt = 0; end
                end else if (m_ph == 1) begin
                    m_cnt++;
                    if (m_cnt == SIG) begin m_ph = 2; m_cnt = 0; m_pol = int_neg; end
                end else begin
                    if (m_s2 == 1 || m_cnt + 1 == DMAX) begin
                        m_res  = (m_s2 == 1) ? m_cnt : DMAX - 1;
                        m_ovr  = (m_s2 == 1) ? 0 : 1;
                        m_neg  = m_pol;
                        m_az   = CYC - SIG - (m_cnt + 1);
                        m_done = 1;
                        m_ph = 0; m_cnt = 0;
                    end else begin
                        m_cnt++;
                    end
                end
            end
            m_div = (m_div + 1) % DIV;
            m_s2 = m_s1;
            m_s1 = int'(cmp_in);
        end
    end

    always @(negedge clk) begin
        if (model_on && !finished) begin
            check("R1", "az_en", int'(az_en), int'(m_ph == 0));
            check("R1", "si_en", int'(si_en), int'(m_ph == 1));
            check("R1", "ri_en", int'(ri_en), int'(m_ph == 2));
            check("R4", "ref_neg", int'(ref_neg), int'(m_ph == 2 && m_pol == 0));
            check("R5", "result", int'(result), m_res);
            check("R8", "result_neg", int'(result_neg), m_neg);
            check("R6", "overrange", int'(overrange), m_ovr);
            check("R8", "done", int'(done), m_done);
        end
    end

    // Phase timing monitors
    int clk_n = 0, si_start = -1, ri_start = -1;
    bit si_q = 1'b0, ri_q = 1'b0;
    always @(negedge clk) begin
        clk_n++;
        if (model_on && !finished) begin
            if (si_en && !si_q) begin
                if (si_start >= 0) check("R7", "signal-start period", clk_n - si_start, CYC * DIV);
                si_start = clk_n;
            end
            if (!si_en && si_q) check("R3", "signal length", clk_n - si_start, SIG * DIV);
            if (ri_en && !ri_q) ri_start = clk_n;
            if (!ri_en && ri_q) check("R2", "ref length mod DIV", (clk_n - ri_start) % DIV, 0);
        end
        si_q = si_en;
        ri_q = ri_en;
    end

    // Per-conversion stimulus: sign, comparator delay after reference start
    // delay >= 0: clocks; -1: never; -2: high from signal phase; -3: pulse in signal, then 12
    int sgn[NCONV] = '{0, 1, 0, 1, 0, 1, 0};
    int dly[NCONV] = '{30, 60, -1, -2, 100, 157, -3};

    task automatic wait_for_si(); while (!si_en) @(negedge clk); endtask
    task automatic wait_for_ri(); while (!ri_en) @(negedge clk); endtask
    task automatic wait_for_az(); while (!az_en) @(negedge clk); endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "reset az_en", int'(az_en), 1);
        check("R9", "reset si_en", int'(si_en), 0);
        check("R9", "reset ri_en", int'(ri_en), 0);
        check("R9", "reset result", int'(result), 0);
        check("R9", "reset overrange", int'(overrange), 0);
        check("R9", "reset done", int'(done), 0);
        check("R9", "reset ref_neg", int'(ref_neg), 0);
        rst = 1'b0;
        model_on = 1'b1;
        for (int i = 0; i < NCONV; i++) begin
            wait_for_si();
            int_neg = sgn[i][0];
            if (dly[i] == -2) cmp_in = 1'b1;
            if (dly[i] == -3) begin
                repeat (5) @(negedge clk);
                cmp_in = 1'b1;
                repeat (8) @(negedge clk);
                cmp_in = 1'b0;
            end
            wait_for_ri();
            if (dly[i] >= 0 || dly[i] == -3) begin
                repeat ((dly[i] == -3) ? 12 : dly[i]) @(negedge clk);
                cmp_in = 1'b1;
            end
            wait_for_az();
            cmp_in = 1'b0;
            if (dly[i] == -1) begin
                check("R6", "clamped result", int'(result), DMAX - 1);
                check("R6", "overrange set", int'(overrange), 1);
            end
            if (dly[i] == -2) begin
                check("R10", "pre-high comparator reading", int'(result), 0);
                check("R10", "pre-high sign", int'(result_neg), 1);
            end
            if (dly[i] == -3)
                check("R10", "signal-phase pulse ignored, reading", int'(result), (12 + 2) / DIV);
        end
        repeat (10) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule